// File: doc/BRIEF.md
# Start-Up Coarse/Fine DAC Calibration Sequencer

This block runs the power-up calibration of a segmented feedback DAC in which a coarse bank of large unit elements and a fine bank of small unit elements share the modulator feedback. The coarse element should weigh exactly 2^RATIO_LOG2 fine elements on average. After a start request the sequencer puts the loop into calibration mode. In that mode the multibit quantizer is cut from the feedback, a single-bit quantizer closes the loop, and the analog input is grounded. The sequencer then drives a fixed DC test code into one bank at a time through that bank's element-rotation path, with the other bank disconnected.

For each bank it counts the ones in the single-bit modulator stream over a window of 2^m samples. This count is an accumulate-and-dump, first-order sinc average. The two counts are weighed against the test codes used, and the sequencer forms one signed trim word for a single fine element. It saturates the word to the trim width, presents it with a one-cycle done pulse, and holds it until the next calibration. The state flow is IDLE → MEAS_CRS → MEAS_FIN → COMPUTE → DONE → IDLE. A start in IDLE moves to MEAS_CRS. The end of the coarse window moves to MEAS_FIN. The end of the fine window moves to COMPUTE. COMPUTE and DONE each last one cycle and always advance.

Top module: `dac_cal_seq`

## Requirements
- R1: While reset is low and after its release, the sequencer is in IDLE with cal_mode_o, crs_sel_o, fin_sel_o and done_o low, test_code_o equal to 0 and trim_o equal to 0.
- R2: A high start_i sampled in IDLE enters MEAS_CRS on the next cycle. In MEAS_CRS, cal_mode_o=1, crs_sel_o=1, fin_sel_o=0 and test_code_o=COARSE_CODE (default 1).
- R3: The window length m is latched at start as min(win_log2_i, MAX_WIN_LOG2). MEAS_CRS lasts exactly 2^m cycles. MEAS_FIN then lasts 2^m cycles, with crs_sel_o=0, fin_sel_o=1 and test_code_o=FINE_CODE (default 8). The two selects are never high together.
- R4: Each measurement counts the ones on mod_bit_i sampled at the clock edges of its own window. The count restarts at zero for each measurement, so no sample of one window enters the other.
- R5: trim = FINE_CODE·Ncrs − 2^RATIO_LOG2·COARSE_CODE·Nfin, saturated to a signed TRIM_W-bit value. With the defaults this is 8·Ncrs − 16·Nfin, clamped to −128..127.
- R6: After the fine window, COMPUTE lasts one cycle and DONE lasts one cycle. done_o is high only in DONE, for exactly one cycle, 2·2^m+2 cycles after the start edge. trim_o holds the new value from that cycle on.
- R7: start_i has no effect in any state other than IDLE. It neither shortens nor restarts a calibration in progress.
- R8: trim_o changes only on entry to DONE and holds its value in all other cycles.
- R9: cal_mode_o is high in MEAS_CRS, MEAS_FIN and COMPUTE, and low in IDLE and DONE. Its high level means the multibit path is cut, single-bit feedback is on and the input is grounded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Calibration request, taken in IDLE only |
| win_log2_i | input | WL_W | Requested log2 of the measurement window, latched at start |
| mod_bit_i | input | 1 | Single-bit modulator output stream |
| cal_mode_o | output | 1 | Calibration mode: single-bit feedback, grounded input |
| crs_sel_o | output | 1 | Coarse bank under test |
| fin_sel_o | output | 1 | Fine bank under test |
| test_code_o | output | CODE_W | DC test code for the bank under test |
| done_o | output | 1 | One-cycle completion pulse |
| trim_o | output | TRIM_W | Signed trim for one fine element |

## Verification
Counted from the edge that samples start, the coarse selects appear one cycle later. The fine selects follow 2^m cycles after that. COMPUTE is visible after edge 2·2^m+1, and done_o and the new trim_o after edge 2·2^m+2. The bench drives every stream bit at a falling edge, so the next rising edge takes it. It checks each output at the falling edge that follows the edge where the value is due, walking the same 2^m count itself. Ones are placed at either the head or the tail of a window, so that losing the first or the last sample changes the expected trim.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_MEAS_CRS = 3'd1,
        ST_MEAS_FIN = 3'd2,
        ST_COMPUTE  = 3'd3,
        ST_DONE     = 3'd4
    } cal_state_e;

endpackage

// File: rtl/cal_seq_fsm.sv
module cal_seq_fsm
    import cal_seq_pkg::*;
#(
    parameter int MAX_WIN_LOG2 = 10,
    parameter int WL_W         = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [WL_W-1:0] win_log2_i,
    output cal_state_e      state_o,
    output logic            sample_o,
    output logic            last_o,
    output logic            launch_o
);

    localparam int CNT_W = MAX_WIN_LOG2 + 1;

    cal_state_e        state_q, state_d;
    logic [WL_W-1:0]   win_m_q;
    logic [CNT_W-1:0]  smp_q;
    logic [CNT_W-1:0]  win_len;

    assign win_len  = CNT_W'(1) << win_m_q;
    assign launch_o = (state_q == ST_IDLE) && start_i;
    assign sample_o = (state_q == ST_MEAS_CRS) || (state_q == ST_MEAS_FIN);
    assign last_o   = sample_o && (smp_q == (win_len - CNT_W'(1)));
    assign state_o  = state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_MEAS_CRS;
            ST_MEAS_CRS: if (last_o)  state_d = ST_MEAS_FIN;
            ST_MEAS_FIN: if (last_o)  state_d = ST_COMPUTE;
            ST_COMPUTE:  state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_m_q <= '0;
            smp_q   <= '0;
        end else begin
            if (launch_o) begin
                win_m_q <= (win_log2_i > WL_W'(MAX_WIN_LOG2)) ? WL_W'(MAX_WIN_LOG2) : win_log2_i;
            end
            if (!sample_o) begin
                smp_q <= '0;
            end else if (last_o) begin
                smp_q <= '0;
            end else begin
                smp_q <= smp_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/cal_seq_acc.sv
module cal_seq_acc #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             en_i,
    input  logic             bit_i,
    input  logic             dump_i,
    output logic [CNT_W-1:0] sum_o
);

    logic [CNT_W-1:0] acc_q;

    assign sum_o = acc_q + CNT_W'(bit_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear_i) begin
            acc_q <= '0;
        end else if (en_i) begin
            acc_q <= dump_i ? '0 : sum_o;
        end
    end

endmodule

// File: rtl/cal_seq_trim.sv
module cal_seq_trim #(
    parameter int CNT_W       = 11,
    parameter int CODE_W      = 4,
    parameter int RATIO_LOG2  = 4,
    parameter int COARSE_CODE = 1,
    parameter int FINE_CODE   = 8,
    parameter int TRIM_W      = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic [CNT_W-1:0]         crs_cnt_i,
    input  logic [CNT_W-1:0]         fin_cnt_i,
    output logic signed [TRIM_W-1:0] trim_o
);

    localparam int RAW_W   = CNT_W + CODE_W + RATIO_LOG2 + 2;
    localparam int NEG_MUL = COARSE_CODE * (1 << RATIO_LOG2);
    localparam logic signed [RAW_W-1:0] T_MAX = RAW_W'((1 << (TRIM_W - 1)) - 1);
    localparam logic signed [RAW_W-1:0] T_MIN = -RAW_W'(1 << (TRIM_W - 1));

    logic signed [RAW_W-1:0] crs_term, fin_term, raw;
    logic signed [TRIM_W-1:0] sat;

    always_comb begin
        crs_term = $signed({{(RAW_W - CNT_W){1'b0}}, crs_cnt_i}) * $signed(RAW_W'(FINE_CODE));
        fin_term = $signed({{(RAW_W - CNT_W){1'b0}}, fin_cnt_i}) * $signed(RAW_W'(NEG_MUL));
        raw      = crs_term - fin_term;
        if (raw > T_MAX) begin
            sat = T_MAX[TRIM_W-1:0];
        end else if (raw < T_MIN) begin
            sat = T_MIN[TRIM_W-1:0];
        end else begin
            sat = raw[TRIM_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trim_o <= '0;
        end else if (load_i) begin
            trim_o <= sat;
        end
    end

endmodule

// File: rtl/dac_cal_seq.sv
module dac_cal_seq
    import cal_seq_pkg::*;
#(
    parameter int MAX_WIN_LOG2 = 10,
    parameter int WL_W         = $clog2(MAX_WIN_LOG2 + 1),
    parameter int CODE_W       = 4,
    parameter int RATIO_LOG2   = 4,
    parameter int COARSE_CODE  = 1,
    parameter int FINE_CODE    = 8,
    parameter int TRIM_W       = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [WL_W-1:0]          win_log2_i,
    input  logic                     mod_bit_i,
    output logic                     cal_mode_o,
    output logic                     crs_sel_o,
    output logic                     fin_sel_o,
    output logic [CODE_W-1:0]        test_code_o,
    output logic                     done_o,
    output logic signed [TRIM_W-1:0] trim_o
);

    localparam int CNT_W = MAX_WIN_LOG2 + 1;

    cal_state_e       state;
    logic             sample, last, launch;
    logic [CNT_W-1:0] win_sum;
    logic [CNT_W-1:0] crs_cnt_q, fin_cnt_q;

    cal_seq_fsm #(
        .MAX_WIN_LOG2(MAX_WIN_LOG2),
        .WL_W        (WL_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .win_log2_i(win_log2_i),
        .state_o   (state),
        .sample_o  (sample),
        .last_o    (last),
        .launch_o  (launch)
    );

    cal_seq_acc #(
        .CNT_W(CNT_W)
    ) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(launch),
        .en_i   (sample),
        .bit_i  (mod_bit_i),
        .dump_i (last),
        .sum_o  (win_sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crs_cnt_q <= '0;
            fin_cnt_q <= '0;
        end else if (last) begin
            if (state == ST_MEAS_CRS) crs_cnt_q <= win_sum;
            if (state == ST_MEAS_FIN) fin_cnt_q <= win_sum;
        end
    end

    cal_seq_trim #(
        .CNT_W      (CNT_W),
        .CODE_W     (CODE_W),
        .RATIO_LOG2 (RATIO_LOG2),
        .COARSE_CODE(COARSE_CODE),
        .FINE_CODE  (FINE_CODE),
        .TRIM_W     (TRIM_W)
    ) u_trim (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (state == ST_COMPUTE),
        .crs_cnt_i(crs_cnt_q),
        .fin_cnt_i(fin_cnt_q),
        .trim_o   (trim_o)
    );

    always_comb begin
        cal_mode_o  = 1'b0;
        crs_sel_o   = 1'b0;
        fin_sel_o   = 1'b0;
        test_code_o = '0;
        done_o      = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_MEAS_CRS: begin
                cal_mode_o  = 1'b1;
                crs_sel_o   = 1'b1;
                test_code_o = CODE_W'(COARSE_CODE);
            end
            ST_MEAS_FIN: begin
                cal_mode_o  = 1'b1;
                fin_sel_o   = 1'b1;
                test_code_o = CODE_W'(FINE_CODE);
            end
            ST_COMPUTE: cal_mode_o = 1'b1;
            ST_DONE:    done_o     = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk #(
    parameter int CODE_W      = 4,
    parameter int TRIM_W      = 8,
    parameter int COARSE_CODE = 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start_i,
    input logic                     cal_mode_o,
    input logic                     crs_sel_o,
    input logic                     fin_sel_o,
    input logic [CODE_W-1:0]        test_code_o,
    input logic                     done_o,
    input logic signed [TRIM_W-1:0] trim_o
);

    // R2
    launch_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !cal_mode_o && !done_o) |=> (crs_sel_o && test_code_o == CODE_W'(COARSE_CODE)));

    // R3
    bank_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(crs_sel_o && fin_sel_o));

    // R3
    fin_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fin_sel_o) |-> $past(crs_sel_o));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(cal_mode_o) && !cal_mode_o));

    // R8
    trim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(trim_o));

    // R9
    bank_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crs_sel_o || fin_sel_o) |-> cal_mode_o);

endmodule

bind dac_cal_seq cal_seq_chk #(
    .CODE_W     (CODE_W),
    .TRIM_W     (TRIM_W),
    .COARSE_CODE(COARSE_CODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .cal_mode_o (cal_mode_o),
    .crs_sel_o  (crs_sel_o),
    .fin_sel_o  (fin_sel_o),
    .test_code_o(test_code_o),
    .done_o     (done_o),
    .trim_o     (trim_o)
);

// File: tb/dac_cal_seq_test.sv
module dac_cal_seq_test;

    localparam int NV = 10;
    // window log2, coarse ones, fine ones, ones at tail, expected trim, start poke
    localparam int V_WL  [NV] = '{4, 4, 4, 5, 5, 3, 6, 3, 0, 15};
    localparam int V_NC  [NV] = '{8, 10, 6, 32, 0, 8, 20, 8, 1, 600};
    localparam int V_NF  [NV] = '{4, 4, 5, 0, 32, 8, 9, 0, 0, 296};
    localparam int V_TL  [NV] = '{0, 1, 0, 0, 1, 0, 1, 1, 0, 1};
    localparam int V_EXP [NV] = '{0, 16, -32, 127, -128, -64, 16, 64, 8, 64};
    localparam int V_PK  [NV] = '{0, 0, 0, 0, 0, 0, 1, 0, 0, 0};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [3:0]        win_log2_i = '0;
    logic              mod_bit_i = 1'b0;
    logic              cal_mode_o, crs_sel_o, fin_sel_o, done_o;
    logic [3:0]        test_code_o;
    logic signed [7:0] trim_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    dac_cal_seq uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .win_log2_i (win_log2_i),
        .mod_bit_i  (mod_bit_i),
        .cal_mode_o (cal_mode_o),
        .crs_sel_o  (crs_sel_o),
        .fin_sel_o  (fin_sel_o),
        .test_code_o(test_code_o),
        .done_o     (done_o),
        .trim_o     (trim_o)
    );

    always #10 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL R6 watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    function automatic logic bit_at(int i, int n, int w, int tail);
        return (tail != 0) ? (i >= w - n) : (i < n);
    endfunction

    task automatic run_vec(int wl, int nc, int nf, int tail, int exp, int poke);
        int m = (wl > 10) ? 10 : wl;
        int w = 1 << m;
        @(negedge clk);
        start_i    = 1'b1;
        win_log2_i = 4'(wl);
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 cal_mode", int'(cal_mode_o), 1);
        chk("R2 crs_sel", int'(crs_sel_o), 1);
        chk("R2 test_code", int'(test_code_o), 1);
        for (int i = 0; i < w; i++) begin
            if (i > 0) @(negedge clk);
            mod_bit_i = bit_at(i, nc, w, tail);
            if (i == w - 1) chk("R3 coarse window end", int'(crs_sel_o), 1);
        end
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            if (i == 0) begin
                chk("R3 fin_sel", int'(fin_sel_o), 1);
                chk("R3 crs_sel off", int'(crs_sel_o), 0);
                chk("R3 test_code", int'(test_code_o), 8);
            end
            mod_bit_i = bit_at(i, nf, w, tail);
            start_i   = (poke != 0 && i == 0) ? 1'b1 : 1'b0;
            if (i == w - 1) chk("R3 fine window end", int'(fin_sel_o), 1);
        end
        @(negedge clk);
        start_i   = 1'b0;
        mod_bit_i = 1'b1;
        chk("R9 compute cal_mode", int'(cal_mode_o), 1);
        chk("R6 no early done", int'(done_o), 0);
        @(negedge clk);
        chk("R6 done", int'(done_o), 1);
        chk("R5 trim", int'(trim_o), exp);
        chk("R9 done cal_mode", int'(cal_mode_o), 0);
        @(negedge clk);
        mod_bit_i = 1'b0;
        chk("R6 done single", int'(done_o), 0);
        chk("R8 trim held", int'(trim_o), exp);
    endtask

    initial begin
        // R1 during and after reset
        repeat (3) @(negedge clk);
        chk("R1 cal_mode in reset", int'(cal_mode_o), 0);
        chk("R1 trim in reset", int'(trim_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done", int'(done_o), 0);
        chk("R1 selects", int'(crs_sel_o) + int'(fin_sel_o), 0);
        chk("R1 test_code", int'(test_code_o), 0);

        // R4 R5 R7 table walk
        for (int v = 0; v < NV; v++) begin
            run_vec(V_WL[v], V_NC[v], V_NF[v], V_TL[v], V_EXP[v], V_PK[v]);
        end

        // R8 idle hold with a busy stream and no start
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            mod_bit_i = 1'(i & 1);
        end
        @(negedge clk);
        chk("R8 trim idle hold", int'(trim_o), 64);
        chk("R9 idle cal_mode", int'(cal_mode_o), 0);

        // R7 start held through a whole run: still one done after 2*2^m+2
        @(negedge clk);
        start_i    = 1'b1;
        win_log2_i = 4'd2;
        mod_bit_i  = 1'b1;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            chk("R7 no early done", int'(done_o), 0);
        end
        @(negedge clk);
        chk("R7 done on time", int'(done_o), 1);
        chk("R5 all ones w4", int'(trim_o), 8 * 4 - 16 * 4);
        start_i = 1'b0;
        @(negedge clk);
        chk("R7 done single", int'(done_o), 0);

        finish_run();
    end

endmodule